// File: doc/BRIEF.md
# Quad-Linear Sum and Hit Output Formatter

Every bunch crossing this block takes the results of a jet-finding and energy-summing stage and turns them into two 25-bit words for a merger module that sits further down the backplane. The hit word carries eight 3-bit jet-hit multiplicities. Any multiplicity larger than 7 is clamped to 7 so that it cannot wrap. The sum word carries three energy sums: scalar transverse energy, the x component and the y component. Each sum is compressed to 8 bits with a quad-linear code, made of a 6-bit mantissa and a 2-bit range field. The range field selects a step of 1, 4, 16 or 64 GeV.

The transverse energy input is 12 bits at 1 GeV per count. The two vector components are 14 bits at 0.25 GeV per count. These are brought to 1 GeV units by dropping their two lowest bits and are treated as unsigned magnitudes. The encoder always uses the finest range in which the value fits and truncates the bits it shifts out. The top bit of each word is an odd parity bit. Both words are registered once per bunch clock, so an output reflects the inputs present at the previous rising edge.

Top module: `qlf_merger_fmt`

## Requirements
- R1: While `rst_n` is low at a rising edge, both output words become the idle value `25'h1000000`: all data bits are 0 and the parity bit is 1.
- R2: Hit lane k is taken from input bits [4k+3:4k] and placed at output bits [3k+2:3k]. Lane 0 is the least significant. A count from 0 to 7 passes through unchanged, one clock after it is presented.
- R3: A hit-lane input from 8 to 15 appears in its output field as 7.
- R4: Bit 24 of the hit word makes the number of ones across bits 24..0 odd.
- R5: An 8-bit energy code holds the mantissa in bits [5:0] and the range in bits [7:6]. A value from 0 to 63 GeV is coded as range 0, with a mantissa equal to the value.
- R6: A value from 64 to 255 is coded as range 1 with mantissa value>>2. A value from 256 to 1023 is range 2 with mantissa value>>4. A value from 1024 to 4095 is range 3 with mantissa value>>6. Any nonzero range therefore has a mantissa of at least 16.
- R7: EX and EY are converted to 1 GeV units by discarding their two least significant bits before encoding.
- R8: In the sum word, the ET code sits at bits [7:0], the EX code at [15:8] and the EY code at [23:16].
- R9: Bit 24 of the sum word makes the number of ones across bits 24..0 odd.
- R10: A value beyond the top range saturates to mantissa 63 with range 3. Full-scale ET (4095) and full-scale EX or EY (16383) each give code `8'hFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_cnt_i | input | 32 | Eight 4-bit raw jet-hit counts, lane 0 in the lowest nibble |
| et_i | input | 12 | Scalar transverse energy sum, 1 GeV per count |
| ex_i | input | 14 | X energy component magnitude, 0.25 GeV per count |
| ey_i | input | 14 | Y energy component magnitude, 0.25 GeV per count |
| hit_word_o | output | 25 | Packed hit multiplicities with odd parity in bit 24 |
| sum_word_o | output | 25 | Packed quad-linear energy codes with odd parity in bit 24 |

## Verification
The bench steps ET across every range edge (63/64, 255/256, 1023/1024) and up to full scale. A design that picked a range that is too coarse, or that rounded instead of truncating, would show a wrong mantissa exactly at these points. Vector components of 3 and 4 quarter-GeV counts expose a component that is not divided by four, or that is rounded. Hit inputs from 8 to 15 catch a count that wraps modulo 8 instead of sticking at 7. Distinct values in every lane and every energy slot catch swapped or shifted fields. Patterns with both even and odd numbers of data ones catch even parity or a parity bit computed over the wrong bits.

// File: rtl/qlf_pkg.sv
// Package: shared widths for the quad-linear sum and hit output formatter.
// Assumes: every derived width below follows from the base parameters.
package qlf_pkg;
    parameter int HIT_LANES   = 8;   // jet-hit multiplicity lanes
    parameter int HIT_IN_W    = 4;   // raw count width per lane
    parameter int HIT_OUT_W   = 3;   // saturating packed width per lane
    parameter int ET_W        = 12;  // scalar sum width, 1 GeV units
    parameter int EXY_W       = 14;  // vector sum width, 0.25 GeV units
    parameter int EXY_DROP    = 2;   // LSBs discarded to reach 1 GeV
    parameter int MANT_W      = 6;   // quad-linear mantissa width
    parameter int RNG_W       = 2;   // quad-linear range field width
    parameter int RNG_STEP    = 2;   // log2 of resolution ratio per range

    localparam int NUM_RANGES = 1 << RNG_W;
    localparam int CODE_W     = MANT_W + RNG_W;
    localparam int NUM_SUMS   = 3;
    localparam int HIT_DATA_W = HIT_LANES * HIT_OUT_W;
    localparam int SUM_DATA_W = NUM_SUMS * CODE_W;
    localparam int EXY_GEV_W  = EXY_W - EXY_DROP;

    typedef logic [MANT_W-1:0] mant_t;
    typedef logic [RNG_W-1:0]  rng_t;

    // One compressed energy sum: range above mantissa.
    typedef struct packed {
        rng_t  rng;
        mant_t mant;
    } qcode_t;
endpackage

// File: rtl/qlf_hit_clamp.sv
// Module: clamps one raw jet-hit count to the saturating output width.
// Assumes: IN_W >= OUT_W; counts are unsigned.
module qlf_hit_clamp #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 3
) (
    input  logic [IN_W-1:0]  cnt_i,
    output logic [OUT_W-1:0] cnt_o
);
    localparam logic [IN_W-1:0] MAX_CNT = IN_W'((1 << OUT_W) - 1);

    // Pass small counts through, stick at the maximum otherwise.
    always_comb begin
        if (cnt_i > MAX_CNT) begin
            cnt_o = '1;
        end else begin
            cnt_o = cnt_i[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/qlf_qlin_enc.sv
// Module: quad-linear encoder, unsigned magnitude to {range, mantissa}.
// Assumes: IN_W > MANT_W; the finest range that fits wins and shifted-out
// bits are truncated; values beyond the coarsest range saturate.
module qlf_qlin_enc
    import qlf_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic [IN_W-1:0] val_i,
    output qcode_t          code_o
);
    logic [NUM_RANGES-1:0] fits;
    logic [IN_W-1:0]       scaled [NUM_RANGES];

    // Build one scaled candidate per range and flag whether it fits.
    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
        assign scaled[r] = val_i >> (RNG_STEP * r);
        assign fits[r]   = (scaled[r] >> MANT_W) == '0;
    end

    // Select the finest fitting range; saturate if none fits.
    always_comb begin
        code_o.rng  = rng_t'(NUM_RANGES - 1);
        code_o.mant = '1;
        for (int r = NUM_RANGES - 1; r >= 0; r--) begin
            if (fits[r]) begin
                code_o.rng  = rng_t'(r);
                code_o.mant = scaled[r][MANT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/qlf_odd_parity.sv
// Module: appends an odd parity bit above a data vector.
// Assumes: the parity bit becomes the new most significant bit.
module qlf_odd_parity #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W:0]   word_o
);
    // Parity bit is set when the data holds an even number of ones.
    always_comb begin
        word_o = {~(^data_i), data_i};
    end
endmodule

// File: rtl/qlf_merger_fmt.sv
// Module: top of the formatter. Clamps and packs eight hit counts, encodes
// three energy sums quad-linearly, adds odd parity to both words and
// registers them once per bunch clock.
// Assumes: synchronous active-low reset; inputs are stable around the edge.
module qlf_merger_fmt
    import qlf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [HIT_LANES*HIT_IN_W-1:0] hit_cnt_i,
    input  logic [ET_W-1:0]              et_i,
    input  logic [EXY_W-1:0]             ex_i,
    input  logic [EXY_W-1:0]             ey_i,
    output logic [HIT_DATA_W:0]          hit_word_o,
    output logic [SUM_DATA_W:0]          sum_word_o
);
    localparam logic [HIT_DATA_W:0] HIT_IDLE = {1'b1, {HIT_DATA_W{1'b0}}};
    localparam logic [SUM_DATA_W:0] SUM_IDLE = {1'b1, {SUM_DATA_W{1'b0}}};
    localparam int                  MIN_UPPER_MANT = 1 << (MANT_W - RNG_STEP);

    logic [HIT_DATA_W-1:0] hit_data;
    logic [HIT_DATA_W:0]   hit_next;
    qcode_t                code_et, code_ex, code_ey;
    logic [SUM_DATA_W-1:0] sum_data;
    logic [SUM_DATA_W:0]   sum_next;

    // Clamp every hit lane into its packed field.
    for (genvar k = 0; k < HIT_LANES; k++) begin : g_hit
        qlf_hit_clamp #(
            .IN_W  (HIT_IN_W),
            .OUT_W (HIT_OUT_W)
        ) u_clamp (
            .cnt_i (hit_cnt_i[k*HIT_IN_W +: HIT_IN_W]),
            .cnt_o (hit_data[k*HIT_OUT_W +: HIT_OUT_W])
        );
    end

    // Encode ET directly and the vector sums after dropping quarter-GeV bits.
    qlf_qlin_enc #(.IN_W(ET_W)) u_enc_et (
        .val_i  (et_i),
        .code_o (code_et)
    );
    qlf_qlin_enc #(.IN_W(EXY_GEV_W)) u_enc_ex (
        .val_i  (ex_i[EXY_W-1:EXY_DROP]),
        .code_o (code_ex)
    );
    qlf_qlin_enc #(.IN_W(EXY_GEV_W)) u_enc_ey (
        .val_i  (ey_i[EXY_W-1:EXY_DROP]),
        .code_o (code_ey)
    );

    assign sum_data = {code_ey, code_ex, code_et};

    qlf_odd_parity #(.DATA_W(HIT_DATA_W)) u_par_hit (
        .data_i (hit_data),
        .word_o (hit_next)
    );
    qlf_odd_parity #(.DATA_W(SUM_DATA_W)) u_par_sum (
        .data_i (sum_data),
        .word_o (sum_next)
    );

    // Output registers, loaded every bunch clock, idle on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_word_o <= HIT_IDLE;
            sum_word_o <= SUM_IDLE;
        end else begin
            hit_word_o <= hit_next;
            sum_word_o <= sum_next;
        end
    end

    // Assertions guarding the output registers.
    p_hit_odd_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        ^hit_word_o == 1'b1);

    p_sum_odd_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        ^sum_word_o == 1'b1);

    for (genvar k = 0; k < HIT_LANES; k++) begin : g_hit_chk
        p_hit_sat_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cnt_i[k*HIT_IN_W +: HIT_IN_W] > HIT_IN_W'((1 << HIT_OUT_W) - 1))
            |=> (hit_word_o[k*HIT_OUT_W +: HIT_OUT_W] == '1));

        p_hit_pass_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cnt_i[k*HIT_IN_W +: HIT_IN_W] <= HIT_IN_W'((1 << HIT_OUT_W) - 1))
            |=> (HIT_IN_W'(hit_word_o[k*HIT_OUT_W +: HIT_OUT_W])
                 == $past(hit_cnt_i[k*HIT_IN_W +: HIT_IN_W])));
    end

    p_et_exact_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (et_i < ET_W'(1 << MANT_W))
        |=> (sum_word_o[CODE_W-1:0] == CODE_W'($past(et_i))));

    p_range_min_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (sum_word_o[CODE_W-1:MANT_W] != '0)
        |-> (int'(sum_word_o[MANT_W-1:0]) >= MIN_UPPER_MANT));
endmodule

// File: tb/qlf_merger_fmt_tb_top.sv
// Scoreboard bench: the driver pushes expected words, the monitor pops and
// compares them one clock later.
module qlf_merger_fmt_tb_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hit_cnt_i = '0;
    logic [11:0] et_i = '0;
    logic [13:0] ex_i = '0;
    logic [13:0] ey_i = '0;
    logic [24:0] hit_word_o;
    logic [24:0] sum_word_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [24:0] exp_hit_q[$];
    logic [24:0] exp_sum_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    qlf_merger_fmt dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_cnt_i  (hit_cnt_i),
        .et_i       (et_i),
        .ex_i       (ex_i),
        .ey_i       (ey_i),
        .hit_word_o (hit_word_o),
        .sum_word_o (sum_word_o)
    );

    // Reference quad-linear code: finest step (1,4,16,64) that fits 6 bits.
    function automatic logic [7:0] ref_code(int v);
        for (int r = 0; r < 4; r++) begin
            if ((v >> (2 * r)) < 64) return {2'(r), 6'(v >> (2 * r))};
        end
        return 8'hFF;
    endfunction

    function automatic logic [24:0] ref_hit(logic [31:0] h);
        logic [23:0] d;
        for (int k = 0; k < 8; k++) begin
            int c = int'(h[4*k +: 4]);
            d[3*k +: 3] = (c > 7) ? 3'd7 : 3'(c);
        end
        return {~(^d), d};
    endfunction

    function automatic logic [24:0] ref_sum(int et, int ex, int ey);
        logic [23:0] d;
        d = {ref_code(ey / 4), ref_code(ex / 4), ref_code(et)};
        return {~(^d), d};
    endfunction

    task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one crossing's inputs and queue the expected words.
    task automatic drive(logic [31:0] h, int et, int ex, int ey, string tag);
        @(negedge clk);
        hit_cnt_i = h;
        et_i = 12'(et);
        ex_i = 14'(ex);
        ey_i = 14'(ey);
        exp_hit_q.push_back(ref_hit(h));
        exp_sum_q.push_back(ref_sum(et, ex, ey));
        tag_q.push_back(tag);
    endtask

    // Monitor: after each edge compare the registered words with the queue.
    always @(posedge clk) begin
        #2;
        if (exp_hit_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            check({t, " hit"}, hit_word_o, exp_hit_q.pop_front());
            check({t, " sum"}, sum_word_o, exp_sum_q.pop_front());
        end
    end

    initial begin
        #(CLK_NS * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset hit", hit_word_o, 25'h1000000);
        check("R1 reset sum", sum_word_o, 25'h1000000);
        rst_n = 1'b1;

        drive(32'h0, 0, 0, 0, "R4 R9 all zero");
        drive(32'h76543210, 5, 8, 12, "R2 R4 distinct lanes");
        drive(32'hFEDCBA98, 1, 0, 0, "R3 saturate");
        drive(32'h8F07A001, 63, 0, 0, "R3 R2 mixed, R5 edge 63");
        drive(32'h1, 64, 0, 0, "R6 ET 64");
        drive(32'h11, 255, 0, 0, "R6 ET 255");
        drive(32'h111, 256, 0, 0, "R6 ET 256");
        drive(32'h1111, 1023, 0, 0, "R6 ET 1023");
        drive(32'h11111, 1024, 0, 0, "R6 ET 1024");
        drive(32'h0, 4095, 16383, 16383, "R10 full scale");
        drive(32'h0, 0, 3, 4, "R7 drop LSBs");
        drive(32'h0, 100, 1000, 9999, "R8 R7 field placement");
        drive(32'h0, 37, 2047, 255, "R5 R8 exact and ranges");
        drive(32'h33333333, 700, 4100, 64, "R9 R6 mixed");

        @(negedge clk);
        hit_cnt_i = 32'h77777777;
        et_i = 12'd500;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run hit", hit_word_o, 25'h1000000);
        check("R1 reset mid-run sum", sum_word_o, 25'h1000000);
        rst_n = 1'b1;
        drive(32'h12345670, 2000, 300, 60, "R2 R6 after reset");
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule